// File: doc/BRIEF.md
# Sense-Data Stereo Serial Transmitter

This block is a bit-clock slave that streams two sensed quantities over a two-channel serial link. While the word clock is low it sends the voltage-sense word. While the word clock is high it sends the current-sense word. The framing is either I2S, where the MSB is one bit clock late, or left-justified, where the MSB comes at once. The bit clock and word clock come from an external master. Both are sampled by the block's own system clock, so every bit-clock edge is seen as a one-cycle event in that domain.

The voltage word can be widened to 24 bits. In that case 8 bits of supply-voltage data sit below the 16 voltage bits. A low-power setting also accepts a 32-bit-clock word period. In that setting only voltage and current are sent. A monitor counts bit clocks per word-clock period. It raises a framing error and silences the data line when the count is wrong.

Top module: `sense_serializer_top`

## Requirements
- R1: After synchronous reset, `sdata` and `frame_err` are 0.
- R2: The half-period with `lrclk` low carries the voltage word and the half-period with `lrclk` high carries the current word (16 bits), MSB first. Without supply append the voltage word is 16 bits.
- R3: With `fmt_lj`=1 (left-justified), the MSB is driven after the first falling bit-clock edge of a half. A receiver therefore captures it at the first rising edge of that half.
- R4: With `fmt_lj`=0 (I2S), each bit comes one bit clock later than in left-justified framing. The first bit of a half repeats the final left-justified bit of the previous half, which is 0 in a 64-clock period.
- R5: With `sup_append_en`=1 and `low_power_en`=0, the voltage word is 24 bits: {voltage[15:0], supply[7:0]}. In low-power mode the append setting is ignored.
- R6: Bit positions after the end of the word are driven 0 until the half ends.
- R7: Each word is captured from the sample inputs at the falling bit-clock edge where `lrclk` changes. Later changes within that half have no effect.
- R8: At each low-going `lrclk` transition, the period just ended is judged (the first after reset excepted). A count other than 64 bit clocks sets `frame_err`, and a correct count clears it. While `frame_err` is 1, `sdata` is 0.
- R9: With `low_power_en`=1, periods of either 32 or 64 bit clocks are accepted.
- R10: If a 65th falling bit-clock edge arrives in one period, `frame_err` is set at once without waiting for the period to end.
- R11: `sdata` changes only at a system-clock edge that registers a falling bit-clock edge, or when `frame_err` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock from the master |
| lrclk | input | 1 | Word clock; low = voltage half, high = current half |
| fmt_lj | input | 1 | 1 = left-justified, 0 = I2S |
| sup_append_en | input | 1 | Append 8 supply bits to the voltage word |
| low_power_en | input | 1 | Accept 32-clock periods; suppress supply append |
| volt_sample | input | 16 | Voltage-sense sample |
| cur_sample | input | 16 | Current-sense sample |
| sup_sample | input | 8 | Supply-voltage sample |
| sdata | output | 1 | Serial data out |
| frame_err | output | 1 | Bit-clock count per period is wrong |

## Verification
A falling bit-clock edge is registered at the next rising system-clock edge, and `sdata` takes its new value at that same edge. The bench therefore reads `sdata` at the following rising bit-clock edge, two system clocks later, as a receiver would. The period judgement is made at the first falling edge of a new period. For that reason `frame_err` is read at bit 0 of the low half and applies to the whole period that follows. The overrun flag appears one registered edge after the 65th fall, and the bench reads it only at the last bit of the long period.

// File: rtl/sds_pkg.sv
package sds_pkg;

    localparam int VOLT_W = 16;
    localparam int CUR_W  = 16;
    localparam int SUP_W  = 8;
    localparam int SLOT_W = 32;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic bit_fall;     // falling bit-clock edge seen this cycle
        logic half_start;   // word clock changed at this fall
        logic frame_start;  // word clock went low at this fall
        logic lr_level;     // word clock level at this fall
    } bit_evt_t;

    function automatic logic [SLOT_W-1:0] pack_half_word(
        input logic              hi_half,
        input logic              append,
        input logic [VOLT_W-1:0] v,
        input logic [CUR_W-1:0]  c,
        input logic [SUP_W-1:0]  s
    );
        if (hi_half)
            return {c, {(SLOT_W-CUR_W){1'b0}}};
        else if (append)
            return {v, s, {(SLOT_W-VOLT_W-SUP_W){1'b0}}};
        else
            return {v, {(SLOT_W-VOLT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/sds_bit_events.sv
module sds_bit_events
    import sds_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk,
    input  logic     lrclk,
    output bit_evt_t evt
);
    logic bclk_q;
    logic lr_prev;
    logic fall;

    assign fall = bclk_q & ~bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b1;
            lr_prev <= 1'b1;
        end else begin
            bclk_q <= bclk;
            if (fall)
                lr_prev <= lrclk;
        end
    end

    always_comb begin
        evt.bit_fall    = fall;
        evt.half_start  = fall & (lrclk != lr_prev);
        evt.frame_start = fall & (lrclk != lr_prev) & ~lrclk;
        evt.lr_level    = lrclk;
    end
endmodule

// File: rtl/sds_frame_mon.sv
module sds_frame_mon
    import sds_pkg::*;
#(
    parameter int PERIOD_BITS    = 64,
    parameter int LP_PERIOD_BITS = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    input  logic     lp_en,
    output logic     err
);
    localparam int CNT_W = $clog2(PERIOD_BITS + 2);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PERIOD_BITS);
    localparam logic [CNT_W-1:0] LP_CNT   = CNT_W'(LP_PERIOD_BITS);

    logic [CNT_W-1:0] cnt;
    logic             seen;
    logic             period_ok;

    assign period_ok = (cnt == FULL_CNT) || (lp_en && (cnt == LP_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            seen <= 1'b0;
            err  <= 1'b0;
        end else if (evt.bit_fall) begin
            if (evt.frame_start) begin
                cnt  <= CNT_W'(1);
                seen <= 1'b1;
                if (seen)
                    err <= ~period_ok;
            end else begin
                if (cnt <= FULL_CNT)
                    cnt <= cnt + 1'b1;
                if (cnt == FULL_CNT)
                    err <= 1'b1;
            end
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT + 1'b1); // R10
    AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (evt.bit_fall && !evt.frame_start && cnt == FULL_CNT) |=> err); // R10
    AST_LP_SHORT_OK: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_start && seen && lp_en && cnt == LP_CNT) |=> !err); // R9
    AST_FULL_OK: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_start && seen && cnt == FULL_CNT) |=> !err); // R8
endmodule

// File: rtl/sds_shifter.sv
module sds_shifter
    import sds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    input  logic [SLOT_W-1:0] word,
    output logic              lj_bit,
    output logic              i2s_bit
);
    logic [SLOT_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            lj_bit  <= 1'b0;
            i2s_bit <= 1'b0;
        end else if (evt.bit_fall) begin
            i2s_bit <= lj_bit;
            if (evt.half_start) begin
                lj_bit <= word[SLOT_W-1];
                shreg  <= {word[SLOT_W-2:0], 1'b0};
            end else begin
                lj_bit <= shreg[SLOT_W-1];
                shreg  <= {shreg[SLOT_W-2:0], 1'b0};
            end
        end
    end

    AST_HALF_LOAD_MSB: assert property (@(posedge clk) disable iff (rst)
        evt.half_start |=> (lj_bit == $past(word[SLOT_W-1]))); // R3
    AST_I2S_ONE_LATE: assert property (@(posedge clk) disable iff (rst)
        evt.bit_fall |=> (i2s_bit == $past(lj_bit))); // R4
    AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (rst)
        !evt.bit_fall |=> ($stable(lj_bit) && $stable(i2s_bit))); // R11
endmodule

// File: rtl/sense_serializer_top.sv
module sense_serializer_top
    import sds_pkg::*;
#(
    parameter int PERIOD_BITS    = 64,
    parameter int LP_PERIOD_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              lrclk,
    input  logic              fmt_lj,
    input  logic              sup_append_en,
    input  logic              low_power_en,
    input  logic [VOLT_W-1:0] volt_sample,
    input  logic [CUR_W-1:0]  cur_sample,
    input  logic [SUP_W-1:0]  sup_sample,
    output logic              sdata,
    output logic              frame_err
);
    bit_evt_t          evt;
    frame_fmt_e        fmt;
    logic [SLOT_W-1:0] next_word;
    logic              lj_bit;
    logic              i2s_bit;

    assign fmt = frame_fmt_e'(fmt_lj);
    assign next_word = pack_half_word(lrclk, sup_append_en & ~low_power_en,
                                      volt_sample, cur_sample, sup_sample);

    sds_bit_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .bclk  (bclk),
        .lrclk (lrclk),
        .evt   (evt)
    );

    sds_frame_mon #(
        .PERIOD_BITS    (PERIOD_BITS),
        .LP_PERIOD_BITS (LP_PERIOD_BITS)
    ) u_mon (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .lp_en (low_power_en),
        .err   (frame_err)
    );

    sds_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .word    (next_word),
        .lj_bit  (lj_bit),
        .i2s_bit (i2s_bit)
    );

    always_comb begin
        if (frame_err)
            sdata = 1'b0;
        else if (fmt == FMT_LJ)
            sdata = lj_bit;
        else
            sdata = i2s_bit;
    end

    AST_ERR_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !sdata); // R8
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!sdata && !frame_err)); // R1
endmodule

// File: tb/sense_serializer_tb.sv
module sense_serializer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b1;
    logic        lrclk = 1'b1;
    logic        fmt_lj = 1'b1;
    logic        sup_append_en = 1'b0;
    logic        low_power_en = 1'b0;
    logic [15:0] volt_sample = '0;
    logic [15:0] cur_sample = '0;
    logic [7:0]  sup_sample = '0;
    logic        sdata;
    logic        frame_err;

    int checks = 0;
    int failures = 0;
    logic prev_last = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sense_serializer_top dut_i (
        .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .fmt_lj(fmt_lj),
        .sup_append_en(sup_append_en), .low_power_en(low_power_en),
        .volt_sample(volt_sample), .cur_sample(cur_sample),
        .sup_sample(sup_sample), .sdata(sdata), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input bit hi);
        if (hi) return {cur_sample, 16'h0};
        if (sup_append_en && !low_power_en) return {volt_sample, sup_sample, 8'h0};
        return {volt_sample, 16'h0};
    endfunction

    function automatic logic lj_at(input logic [31:0] w, input int p);
        if (p < 0 || p > 31) return 1'b0;
        return w[31-p];
    endfunction

    task automatic tick(input logic lr, output logic d, output logic e);
        @(negedge clk); bclk = 1'b0; lrclk = lr;
        @(negedge clk);
        @(negedge clk); bclk = 1'b1; d = sdata; e = frame_err;
        @(negedge clk);
    endtask

    // exp_es/exp_ee: expected frame_err at first/last bit; 2 = not checked
    task automatic run_period(input int n, input bit mid, input bit chk_data,
                              input int exp_es, input int exp_ee, input string lab);
        logic [127:0] act_lo = '0, act_hi = '0, exp_lo = '0, exp_hi = '0;
        logic [31:0] wl, wh;
        logic d, e, es = 1'b0, ee = 1'b0;
        logic first_hi;
        int h = n / 2;
        wl = exp_word(1'b0);
        for (int p = 0; p < h; p++) begin
            tick(1'b0, d, e);
            if (p == 0) es = e;
            act_lo[p] = d;
            if (mid && p == 3) volt_sample = ~volt_sample;
        end
        wh = exp_word(1'b1);
        for (int p = 0; p < n - h; p++) begin
            tick(1'b1, d, e);
            act_hi[p] = d;
            ee = e;
            if (mid && p == 3) cur_sample = ~cur_sample;
        end
        for (int p = 0; p < h; p++)
            exp_lo[p] = es ? 1'b0 : (fmt_lj ? lj_at(wl, p)
                                   : (p == 0 ? prev_last : lj_at(wl, p - 1)));
        first_hi = lj_at(wl, h - 1);
        for (int p = 0; p < n - h; p++)
            exp_hi[p] = es ? 1'b0 : (fmt_lj ? lj_at(wh, p)
                                   : (p == 0 ? first_hi : lj_at(wh, p - 1)));
        prev_last = lj_at(wh, n - h - 1);
        if (chk_data) begin
            check(act_lo == exp_lo, {lab, " low half R2 R6"}, act_lo, exp_lo);
            check(act_hi == exp_hi, {lab, " high half R2 R6"}, act_hi, exp_hi);
        end
        if (exp_es != 2)
            check(es == exp_es[0], {lab, " err at start R8"}, 128'(es), 128'(exp_es));
        if (exp_ee != 2)
            check(ee == exp_ee[0], {lab, " err at end R10"}, 128'(ee), 128'(exp_ee));
    endtask

    task automatic set_samples(input int k);
        volt_sample = 16'(16'hA5C3 ^ (k * 16'h1357));
        cur_sample  = 16'(16'h3C5A + (k * 16'h0F1D));
        sup_sample  = 8'(8'hB1 ^ (k * 8'h27));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sdata == 1'b0 && frame_err == 1'b0, "R1 during reset",
              {sdata, frame_err}, 128'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sdata == 1'b0 && frame_err == 1'b0, "R1 after reset",
              {sdata, frame_err}, 128'h0);

        // R3 left-justified, 16-bit voltage, patterns
        fmt_lj = 1'b1; sup_append_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            set_samples(k);
            run_period(64, 1'b0, 1'b1, 0, 0, "R3 LJ");
        end
        // R5 left-justified with supply append
        sup_append_en = 1'b1;
        for (int k = 4; k < 7; k++) begin
            set_samples(k);
            run_period(64, 1'b0, 1'b1, 0, 0, "R5 LJ append");
        end
        // R4 I2S framing, with and without append
        fmt_lj = 1'b0; sup_append_en = 1'b0;
        for (int k = 7; k < 10; k++) begin
            set_samples(k);
            run_period(64, 1'b0, 1'b1, 0, 0, "R4 I2S");
        end
        sup_append_en = 1'b1;
        for (int k = 10; k < 12; k++) begin
            set_samples(k);
            run_period(64, 1'b0, 1'b1, 0, 0, "R4 R5 I2S append");
        end
        // R7 inputs changed mid-half have no effect
        fmt_lj = 1'b1;
        set_samples(12);
        run_period(64, 1'b1, 1'b1, 0, 0, "R7 LJ capture");
        fmt_lj = 1'b0;
        set_samples(13);
        run_period(64, 1'b1, 1'b1, 0, 0, "R7 I2S capture");

        // R9 low power: 32-clock periods, append ignored (R5)
        low_power_en = 1'b1; sup_append_en = 1'b1;
        for (int k = 14; k < 17; k++) begin
            set_samples(k);
            run_period(32, 1'b0, 1'b1, 0, 0, "R9 R5 LP I2S 32");
        end
        fmt_lj = 1'b1;
        set_samples(17);
        run_period(32, 1'b0, 1'b1, 0, 0, "R9 LP LJ 32");
        set_samples(18);
        run_period(64, 1'b0, 1'b1, 0, 0, "R9 LP LJ 64");
        set_samples(19);
        run_period(64, 1'b0, 1'b1, 0, 0, "R9 LP 64 judged");

        // R8 short period in normal mode
        low_power_en = 1'b0; sup_append_en = 1'b0; fmt_lj = 1'b0;
        set_samples(20);
        run_period(32, 1'b0, 1'b1, 0, 0, "R8 short period");
        set_samples(21);
        run_period(64, 1'b0, 1'b1, 1, 1, "R8 forced low");
        set_samples(22);
        run_period(64, 1'b0, 1'b1, 0, 0, "R8 recovered");

        // R10 overrun period
        fmt_lj = 1'b1;
        set_samples(23);
        run_period(80, 1'b0, 1'b0, 0, 1, "R10 overrun");
        set_samples(24);
        run_period(64, 1'b0, 1'b1, 1, 1, "R10 R8 after overrun");
        set_samples(25);
        run_period(64, 1'b0, 1'b1, 0, 0, "R8 recovered again");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule